// File: doc/BRIEF.md
# Selectable-Source Microsecond and Millisecond Tick Generator

This block turns either the system clock or a slow external reference clock into two tick strobes for non-volatile memory timing counters. One strobe marks each elapsed microsecond and is used by the program-phase timers. The other marks each elapsed millisecond and is used by the erase-phase timers. Both strobes are one system-clock cycle wide and live in the system clock domain. The external reference is brought into that domain by a two-flop synchroniser, and only its rising edges count.

A 2-bit source selector chooses among three modes. In the system-only mode, the microsecond divider runs on the system clock and the millisecond tick is made by counting a fixed number of microsecond ticks. In the split mode, the millisecond divider counts external edges while the microsecond divider stays on the system clock. In the all-external mode, both dividers count external edges. The microsecond divider uses its count field directly as the period. The millisecond divider uses its field plus one. Whenever the effective mode or either count changes, both dividers restart from zero. A build parameter can remove external-clock support entirely. The block then always runs in the system-only mode and disregards the erase count.

Top module: `flash_tick_gen`

## Requirements
- R1: While reset is asserted, both tick outputs stay low.
- R2: When the microsecond divider runs on the system clock (selector 00, 01 or 11), `us_tick` rises once every `wr_count` system cycles. A `wr_count` of 0 or 1 gives a tick on every cycle.
- R3: In selector 00 (or 11), `ms_tick` rises once every `US_PER_MS` microsecond ticks, exactly one cycle after the last of them.
- R4: In selector 01, `ms_tick` rises once every `er_count`+1 synchronised rising edges of `ext_clk`. Meanwhile `us_tick` keeps its system-clock period.
- R5: In selector 10, `us_tick` rises once every `wr_count` external rising edges, and `ms_tick` once every `er_count`+1 external rising edges. An `er_count` of 0 gives a tick on every edge, and in this mode each tick lasts one cycle.
- R6: Selector 11 behaves exactly as selector 00.
- R7: A change of the effective selector, of `wr_count` or of `er_count` clears both ticks on the next edge. The first following `us_tick` on the system clock then comes exactly `wr_count` cycles after that edge.
- R8: With `EXT_EN`=0, the selector is treated as 00 whatever its value, and `er_count` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Slow external reference clock, asynchronous |
| wr_count | input | WR_W | Microsecond divider period, in source cycles |
| er_count | input | ER_W | Millisecond divider period minus one, in external edges |
| src_sel | input | 2 | Source selector: 00 system, 01 external for ms, 10 external for both, 11 as 00 |
| us_tick | output | 1 | Microsecond tick strobe |
| ms_tick | output | 1 | Millisecond tick strobe |

## Verification
The single-cycle property of the external-mode ticks assumes that `ext_clk` stays in each level for at least two system cycles, so that synchronised rising edges can never fall on adjacent cycles. The restart property assumes that the configuration does not change at the first edge after reset. The stimulus meets both conditions. The reference clock toggles every four system cycles. Configuration changes are driven just after a rising edge and only once reset has settled. Expected tick spacings are derived from the count fields, the selector and the fixed eight-cycle reference period.

// File: rtl/flash_tick_gen.sv
module flash_tick_gen #(
  parameter int EXT_EN    = 1,
  parameter int WR_W      = 8,
  parameter int ER_W      = 10,
  parameter int US_PER_MS = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_clk,
  input  logic [WR_W-1:0] wr_count,
  input  logic [ER_W-1:0] er_count,
  input  logic [1:0]      src_sel,
  output logic            us_tick,
  output logic            ms_tick
);
  localparam int UPM_W = $clog2(US_PER_MS);
  localparam int MS_W  = (ER_W > UPM_W) ? ER_W : UPM_W;
  localparam int CFG_W = 2 + WR_W + ER_W;
  localparam logic [1:0] SRC_SYS = 2'b00, SRC_EXT_ALL = 2'b10;

  logic            ext_rise;
  logic [1:0]      mode;
  logic [ER_W-1:0] er_eff;

  generate
    if (EXT_EN != 0) begin : g_ext
      logic [2:0] ext_sync;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[1:0], ext_clk};
      assign ext_rise = ext_sync[1] & ~ext_sync[2];
      assign mode     = (src_sel == 2'b11) ? SRC_SYS : src_sel;
      assign er_eff   = er_count;
    end else begin : g_noext
      logic unused_ext;
      assign unused_ext = ext_clk ^ (^er_count) ^ (^src_sel);
      assign ext_rise   = 1'b0;
      assign mode       = SRC_SYS;
      assign er_eff     = '0;
    end
  endgenerate

  logic [CFG_W-1:0] cfg, cfg_q;
  logic [WR_W-1:0]  us_cnt;
  logic [MS_W-1:0]  ms_cnt, ms_limit;
  logic             us_en, us_hit, ms_en, ms_hit, restart;

  assign cfg      = {mode, wr_count, er_eff};
  assign restart  = cfg != cfg_q;
  assign us_en    = (mode == SRC_EXT_ALL) ? ext_rise : 1'b1;
  assign us_hit   = ({1'b0, us_cnt} + 1'b1) >= {1'b0, wr_count};
  assign ms_en    = (mode == SRC_SYS) ? us_tick : ext_rise;
  assign ms_limit = (mode == SRC_SYS) ? MS_W'(US_PER_MS - 1) : MS_W'(er_eff);
  assign ms_hit   = ms_cnt >= ms_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      us_cnt  <= '0;
      ms_cnt  <= '0;
      us_tick <= 1'b0;
      ms_tick <= 1'b0;
    end else if (restart) begin
      cfg_q   <= cfg;
      us_cnt  <= '0;
      ms_cnt  <= '0;
      us_tick <= 1'b0;
      ms_tick <= 1'b0;
    end else begin
      us_tick <= us_en & us_hit;
      ms_tick <= ms_en & ms_hit;
      if (us_en) us_cnt <= us_hit ? '0 : us_cnt + 1'b1;
      if (ms_en) ms_cnt <= ms_hit ? '0 : ms_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flash_tick_gen_chk.sv
module flash_tick_gen_chk #(
  parameter int EXT_EN    = 1,
  parameter int WR_W      = 8,
  parameter int ER_W      = 10,
  parameter int US_PER_MS = 1000
) (
  input logic            clk,
  input logic            rst_n,
  input logic [WR_W-1:0] wr_count,
  input logic [ER_W-1:0] er_count,
  input logic [1:0]      src_sel,
  input logic            us_tick,
  input logic            ms_tick
);
  logic [1:0] eff;
  logic [2+WR_W+ER_W-1:0] cfg_now;
  assign eff     = (EXT_EN != 0 && src_sel != 2'b11) ? src_sel : 2'b00;
  assign cfg_now = {eff, wr_count, (EXT_EN != 0) ? er_count : {ER_W{1'b0}}};

  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r1: assert (!us_tick && !ms_tick);

  p_us_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (us_tick && eff != 2'b10 && wr_count >= 2 && $stable(cfg_now)) |=> !us_tick);

  p_ms_follows_us_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tick && $past(eff) == 2'b00) |-> $past(us_tick));

  p_ext_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((us_tick && eff == 2'b10) || (ms_tick && eff != 2'b00)) |=>
      !((us_tick && eff == 2'b10) || (ms_tick && eff != 2'b00)));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_now != $past(cfg_now)) |=> (!us_tick && !ms_tick));

  p_forced_sys_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_EN == 0 && ms_tick) |-> $past(us_tick));
endmodule

bind flash_tick_gen flash_tick_gen_chk #(
  .EXT_EN(EXT_EN), .WR_W(WR_W), .ER_W(ER_W), .US_PER_MS(US_PER_MS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_count(wr_count), .er_count(er_count),
  .src_sel(src_sel), .us_tick(us_tick), .ms_tick(ms_tick)
);

// File: tb/flash_tick_gen_bench.sv
module flash_tick_gen_bench;
  localparam int K = 5;
  localparam int HALF = 4;
  localparam int EXT_PER = 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0;
  logic [7:0] wr = 8'd1;
  logic [9:0] er = 10'd0;
  logic [1:0] src = 2'b00;
  logic us_tick, ms_tick, us_n, ms_n;

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  always begin
    repeat (HALF) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  flash_tick_gen #(.EXT_EN(1), .US_PER_MS(K)) u_flash_tick_gen (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_count(wr), .er_count(er),
    .src_sel(src), .us_tick(us_tick), .ms_tick(ms_tick));

  flash_tick_gen #(.EXT_EN(0), .US_PER_MS(K)) u_flash_tick_gen_noext (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_count(wr), .er_count(er),
    .src_sel(src), .us_tick(us_n), .ms_tick(ms_n));

  int checks = 0, errors = 0;
  int q_us[$], q_ms[$];
  int last_us = 0, last_ms = 0;
  string cur_req = "R0";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int e;
    if (rst_n) begin
      if (us_tick && cyc > last_us) begin
        if (q_us.size() > 0) begin
          e = q_us.pop_front();
          if (e >= 0) chk((cyc - last_us) == e, cur_req, "us_tick interval", cyc - last_us, e);
        end
        last_us = cyc;
      end
      if (ms_tick && cyc > last_ms) begin
        if (q_ms.size() > 0) begin
          e = q_ms.pop_front();
          if (e >= 0) chk((cyc - last_ms) == e, cur_req, "ms_tick interval", cyc - last_ms, e);
        end
        last_ms = cyc;
      end
    end
  end

  task automatic run_phase(input logic [1:0] m, input int w, input int ee, input string req,
                           input int n_us, input int us_first, input int us_step,
                           input int n_ms, input int ms_first, input int ms_step);
    bit done;
    @(posedge clk); #1;
    src = m; wr = w[7:0]; er = ee[9:0];
    cur_req = req;
    last_us = cyc + 1; last_ms = cyc + 1;
    q_us.delete(); q_ms.delete();
    q_us.push_back(us_first);
    for (int i = 1; i < n_us; i++) q_us.push_back(us_step);
    q_ms.push_back(ms_first);
    for (int i = 1; i < n_ms; i++) q_ms.push_back(ms_step);
    done = 1'b0;
    for (int i = 0; i < 4000 && !done; i++) begin
      @(negedge clk); #1;
      done = (q_us.size() == 0) && (q_ms.size() == 0);
    end
    chk(done, req, "pending expected ticks", q_us.size() + q_ms.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nu, nm;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!us_tick && !ms_tick, "R1", "ticks in reset", us_tick + ms_tick, 0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_phase(2'b00, 3, 0, "R2/R7", 6, 3, 3, 3, K*3+1, K*3);
    run_phase(2'b00, 5, 0, "R7", 3, 5, 5, 2, K*5+1, K*5);
    run_phase(2'b00, 1, 0, "R2", 8, 1, 1, 3, K+1, K);
    run_phase(2'b00, 0, 0, "R2", 8, 1, 1, 3, K+1, K);
    run_phase(2'b00, 2, 0, "R3", 4, 2, 2, 4, K*2+1, K*2);
    run_phase(2'b11, 4, 9, "R6", 5, 4, 4, 3, K*4+1, K*4);
    run_phase(2'b01, 2, 3, "R4", 6, 2, 2, 3, -1, 4*EXT_PER);
    run_phase(2'b10, 2, 1, "R5", 4, -1, 2*EXT_PER, 4, -1, 2*EXT_PER);
    run_phase(2'b10, 1, 0, "R5", 5, -1, EXT_PER, 5, -1, EXT_PER);

    run_phase(2'b10, 2, 7, "R5", 3, -1, 2*EXT_PER, 2, -1, 8*EXT_PER);
    nu = 0; nm = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      nu += int'(us_n);
      nm += int'(ms_n);
    end
    chk(nu == 20, "R8", "forced-system us ticks in 40 cycles", nu, 20);
    chk(nm == 4, "R8", "forced-system ms ticks in 40 cycles", nm, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule